// File: doc/BRIEF.md
# SHA-256 Mailbox Hash Engine

This block computes SHA-256 over message blocks that software places in a shared, word-addressed 32-bit memory. Software talks to it through one mailbox word at a fixed address. The engine keeps reading that word. A zero there means there is nothing to do. A nonzero word carries an operation code and a word pointer. The engine performs the operation and then writes zero back to the mailbox, which tells the requester that the work is finished.

A hash operation fetches sixteen words starting at the pointer and reverses the byte order of each one. It then extends them into a 64-entry message schedule, runs the 64 compression rounds and adds the result into the running hash state. Consecutive hash operations therefore chain, so software can hash a padded message one block at a time. A digest operation stores the eight state words at the pointer and then returns the state to the standard initial value, ready for the next message. Padding, length encoding and arbitration of the memory belong to software and to the system.

The memory side is a single valid/ready request port with a separate read-response strobe. Read data may arrive any number of cycles after the request is accepted.

Top module: `sha_mbox_engine`

## Requirements
- R1: While the mailbox word reads as zero, or its code field (bits 1:0) is 0, the engine issues only reads of address MBOX_ADDR and never writes anything, including the mailbox itself.
- R2: The operation code is bits 1:0 of the mailbox word and the word pointer is bits 16:2, zero-extended to the address width. Bits 31:17 are ignored.
- R3: Code 1 reads the words at pointer+0 to pointer+15 in ascending order. Each word is byte-reversed before use, so bits 7:0 of the stored word become bits 31:24 of the message word.
- R4: A hash operation applies the full SHA-256 compression to the current state: schedule extension, 64 rounds with the standard round constants, and addition into the state. The state carries over between successive hash operations.
- R5: Code 2 writes state words h0 to h7, in that order, to pointer+0 to pointer+7, with no byte reversal.
- R6: The state equals the SHA-256 initial value after reset and immediately after the last digest word has been written.
- R7: Code 3 changes no state. Its only memory access is the write that clears the mailbox.
- R8: Every operation with a nonzero code ends with a write of zero to MBOX_ADDR, and that write is its last access.
- R9: A request holds its address, write enable and write data stable while valid is high and ready is low. At most one read is outstanding at any time. Read latency may be any length.
- R10: No request is raised while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The assertions check the request handshake on every cycle: a stalled request must stay stable, and no second read may be issued while one is pending. They also check that no write appears unless a command is in progress, that each mailbox clear is the last access of its command, that the clear carries zero, and that the state equals the initial value at start-up and after every digest store. Only the bench's scenarios can show the arithmetic. These cover a known-answer block, chained blocks of random data, a digest that returns the initial value, the no-op code, an idle mailbox, a zero code under a nonzero word, and a pointer whose high bits are set. Each is compared against a behavioural model, with random ready stalls and random read latency.

// File: rtl/sha_mbox_pkg.sv
package sha_mbox_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_POLL_W, S_LD, S_LD_W,
        S_EXP, S_RND, S_FOLD, S_DUMP, S_DONE
    } eng_st_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0, OP_HASH = 2'd1, OP_DUMP = 2'd2, OP_NOP = 2'd3
    } op_t;

    typedef struct packed {
        word_t a, b, c, d, e, f, g, h;
    } vars_t;

    localparam vars_t IV_C = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    localparam word_t K_TAB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic word_t byte_rev(input word_t x);
        word_t r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = x[8*(3-i) +: 8];
        return r;
    endfunction

    function automatic word_t sml_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic vars_t round_step(input vars_t v, input word_t kw);
        word_t t1, t2;
        t1 = v.h + big_sig1(v.e) + ((v.e & v.f) ^ (~v.e & v.g)) + kw;
        t2 = big_sig0(v.a) + ((v.a & v.b) ^ (v.a & v.c) ^ (v.b & v.c));
        return '{a: t1 + t2, b: v.a, c: v.b, d: v.c,
                 e: v.d + t1, f: v.e, g: v.f, h: v.g};
    endfunction

    function automatic vars_t vars_add(input vars_t x, input vars_t y);
        return '{a: x.a + y.a, b: x.b + y.b, c: x.c + y.c, d: x.d + y.d,
                 e: x.e + y.e, f: x.f + y.f, g: x.g + y.g, h: x.h + y.h};
    endfunction

    function automatic word_t vars_word(input vars_t v, input logic [2:0] i);
        case (i)
            3'd0: return v.a;
            3'd1: return v.b;
            3'd2: return v.c;
            3'd3: return v.d;
            3'd4: return v.e;
            3'd5: return v.f;
            3'd6: return v.g;
            default: return v.h;
        endcase
    endfunction

endpackage

// File: rtl/sha_msg_sched.sv
module sha_msg_sched
    import sha_mbox_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  word_t         ld_raw,
    input  logic          ex_en,
    input  logic [IW-1:0] ex_idx,
    input  logic [IW-1:0] rd_idx,
    output word_t         rd_word
);
    word_t w_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            w_mem[ld_idx] <= byte_rev(ld_raw);
        end else if (ex_en) begin
            w_mem[ex_idx] <= sml_sig1(w_mem[ex_idx - IW'(2)]) + w_mem[ex_idx - IW'(7)]
                           + sml_sig0(w_mem[ex_idx - IW'(15)]) + w_mem[ex_idx - IW'(16)];
        end
    end

    assign rd_word = w_mem[rd_idx];
endmodule

// File: rtl/sha_round_unit.sv
module sha_round_unit
    import sha_mbox_pkg::*;
(
    input  logic  clk,
    input  logic  load_en,
    input  vars_t load_vars,
    input  logic  step_en,
    input  word_t step_kw,
    output vars_t work_vars
);
    vars_t work_q;

    always_ff @(posedge clk) begin
        if (load_en)      work_q <= load_vars;
        else if (step_en) work_q <= round_step(work_q, step_kw);
    end

    assign work_vars = work_q;
endmodule

// File: rtl/sha_hash_regs.sv
module sha_hash_regs
    import sha_mbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_iv,
    input  logic  fold_en,
    input  vars_t fold_vars,
    output vars_t state
);
    vars_t state_q;

    always_ff @(posedge clk) begin
        if (rst || set_iv) state_q <= IV_C;
        else if (fold_en)  state_q <= vars_add(state_q, fold_vars);
    end

    assign state = state_q;
endmodule

// File: rtl/sha_mbox_engine.sv
module sha_mbox_engine
    import sha_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = '0,
    parameter int                ROUNDS    = 64,
    parameter int                BLK_WORDS = 16,
    parameter int                DIG_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata
);
    localparam int IW = $clog2(ROUNDS);
    localparam logic [IW-1:0] LAST_LD  = IW'(BLK_WORDS - 1);
    localparam logic [IW-1:0] FIRST_EX = IW'(BLK_WORDS);
    localparam logic [IW-1:0] LAST_RND = IW'(ROUNDS - 1);
    localparam logic [IW-1:0] LAST_DIG = IW'(DIG_WORDS - 1);

    eng_st_t           st;
    logic [IW-1:0]     idx;
    logic [ADDR_W-1:0] ptr;
    vars_t             hash_q;
    vars_t             work_q;
    word_t             w_rd;
    logic              acc;
    logic              unused_hi;

    assign acc       = mem_req_valid && mem_req_ready;
    assign unused_hi = ^mem_rsp_rdata[31:17];

    always_comb begin
        mem_req_valid = (st == S_POLL) || (st == S_LD) || (st == S_DUMP) || (st == S_DONE);
        mem_req_we    = (st == S_DUMP) || (st == S_DONE);
        mem_req_addr  = ((st == S_POLL) || (st == S_DONE)) ? MBOX_ADDR : ptr + ADDR_W'(idx);
        mem_req_wdata = (st == S_DUMP) ? vars_word(hash_q, idx[2:0]) : '0;
    end

    sha_msg_sched #(.DEPTH(ROUNDS)) sched_i (
        .clk     (clk),
        .ld_en   (st == S_LD_W && mem_rsp_valid),
        .ld_idx  (idx),
        .ld_raw  (mem_rsp_rdata),
        .ex_en   (st == S_EXP),
        .ex_idx  (idx),
        .rd_idx  (idx),
        .rd_word (w_rd)
    );

    sha_round_unit round_i (
        .clk       (clk),
        .load_en   (st == S_EXP && idx == LAST_RND),
        .load_vars (hash_q),
        .step_en   (st == S_RND),
        .step_kw   (K_TAB[idx] + w_rd),
        .work_vars (work_q)
    );

    sha_hash_regs hregs_i (
        .clk       (clk),
        .rst       (rst),
        .set_iv    (st == S_DUMP && acc && idx == LAST_DIG),
        .fold_en   (st == S_FOLD),
        .fold_vars (work_q),
        .state     (hash_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            idx <= '0;
            ptr <= '0;
        end else begin
            case (st)
                S_IDLE: st <= S_POLL;
                S_POLL: if (acc) st <= S_POLL_W;
                S_POLL_W: if (mem_rsp_valid) begin
                    ptr <= ADDR_W'(mem_rsp_rdata[16:2]);
                    idx <= '0;
                    case (op_t'(mem_rsp_rdata[1:0]))
                        OP_HASH: st <= S_LD;
                        OP_DUMP: st <= S_DUMP;
                        OP_NOP:  st <= S_DONE;
                        default: st <= S_POLL;
                    endcase
                end
                S_LD: if (acc) st <= S_LD_W;
                S_LD_W: if (mem_rsp_valid) begin
                    if (idx == LAST_LD) begin
                        idx <= FIRST_EX;
                        st  <= S_EXP;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= S_LD;
                    end
                end
                S_EXP: begin
                    if (idx == LAST_RND) begin
                        idx <= '0;
                        st  <= S_RND;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_RND: begin
                    if (idx == LAST_RND) begin
                        idx <= '0;
                        st  <= S_FOLD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_FOLD: st <= S_DONE;
                S_DUMP: if (acc) begin
                    if (idx == LAST_DIG) begin
                        idx <= '0;
                        st  <= S_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_DONE: if (acc) st <= S_POLL;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sha_mbox_chk.sv
module sha_mbox_chk
    import sha_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [31:0]       mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic [31:0]       mem_rsp_rdata,
    input eng_st_t           st,
    input vars_t             hash_q
);
    logic [1:0] rd_out;
    logic       cmd_live;
    logic       rst_d;
    logic       clr_acc;

    assign clr_acc = mem_req_valid && mem_req_ready && mem_req_we
                  && mem_req_addr == MBOX_ADDR && st != S_DUMP;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            rd_out   <= '0;
            cmd_live <= 1'b0;
        end else begin
            rd_out <= rd_out + 2'(mem_req_valid && mem_req_ready && !mem_req_we)
                             - 2'(mem_rsp_valid);
            if (st == S_POLL_W && mem_rsp_valid && mem_rsp_rdata[1:0] != 2'b00)
                cmd_live <= 1'b1;
            else if (clr_acc)
                cmd_live <= 1'b0;
        end
    end

    // R10
    always @(posedge clk) begin
        if (rst && rst_d) a_r10_quiet_in_reset: assert (!mem_req_valid);
    end

    a_r9_hold_req: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
            && $stable(mem_req_addr) && $stable(mem_req_wdata));

    a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_we |-> rd_out == 2'd0);

    a_r1_write_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |-> cmd_live);

    a_r8_clear_is_last: assert property (@(posedge clk) disable iff (rst)
        clr_acc |-> mem_req_wdata == 32'd0 ##1 st == S_POLL);

    a_r6_iv_after_dump: assert property (@(posedge clk) disable iff (rst)
        st == S_DONE && $past(st) == S_DUMP |-> hash_q == IV_C);

    a_r6_iv_at_start: assert property (@(posedge clk) disable iff (rst)
        st == S_IDLE |-> hash_q == IV_C);
endmodule

bind sha_mbox_engine sha_mbox_chk #(.ADDR_W(ADDR_W), .MBOX_ADDR(MBOX_ADDR)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .st            (st),
    .hash_q        (hash_q)
);

// File: tb/sha_mbox_engine_tb.sv
`timescale 1ns/1ps
module sha_mbox_engine_tb_top;
    import sha_mbox_pkg::*;

    localparam int          AW   = 16;
    localparam logic [15:0] MBOX = 16'h0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;

    always #4 clk = ~clk;

    sha_mbox_engine #(.ADDR_W(AW), .MBOX_ADDR(MBOX)) dut_i (
        .clk(clk), .rst(rst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    logic [31:0] mem [1024];
    logic        h_we = 1'b0;
    logic [15:0] h_a  = '0;
    logic [31:0] h_d  = '0;
    logic        pend = 1'b0;
    int          lat  = 0;
    logic [31:0] pdata;

    logic [15:0] exp_ra[$];
    logic [15:0] exp_wa[$];
    logic [31:0] exp_wd[$];
    string       exp_wt[$];

    int mon_cmp = 0, mon_bad = 0, seq_cmp = 0, seq_bad = 0, wd_bad = 0, cyc = 0;
    logic [31:0] mh [8];

    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
    end

    // memory model and per-clock comparison against the expected access streams
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= ($urandom % 4) != 0;
        mem_rsp_valid <= 1'b0;
        if (h_we) mem[h_a[9:0]] <= h_d;
        if (pend) begin
            if (lat == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= pdata;
                pend          <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr[9:0]] <= mem_req_wdata;
                mon_cmp <= mon_cmp + 1;
                if (exp_wa.size() == 0) begin
                    mon_bad <= mon_bad + 1;
                    $display("FAIL R1 unexpected write addr %h data %h (expected no write)",
                             mem_req_addr, mem_req_wdata);
                end else begin
                    if (mem_req_addr != exp_wa[0] || mem_req_wdata != exp_wd[0]) begin
                        mon_bad <= mon_bad + 1;
                        $display("FAIL %s write act %h:%h exp %h:%h", exp_wt[0],
                                 mem_req_addr, mem_req_wdata, exp_wa[0], exp_wd[0]);
                    end
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                    void'(exp_wt.pop_front());
                end
            end else begin
                pend  <= 1'b1;
                lat   <= $urandom % 6;
                pdata <= mem[mem_req_addr[9:0]];
                if (mem_req_addr != MBOX) begin
                    mon_cmp <= mon_cmp + 1;
                    if (exp_ra.size() == 0 || exp_ra[0] != mem_req_addr) begin
                        mon_bad <= mon_bad + 1;
                        $display("FAIL R3 read addr act %h exp %h", mem_req_addr,
                                 (exp_ra.size() == 0) ? 16'hxxxx : exp_ra[0]);
                    end
                    if (exp_ra.size() != 0) void'(exp_ra.pop_front());
                end
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 mon_cmp + seq_cmp + wd_bad, mon_bad + seq_bad + wd_bad);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            wd_bad <= 1;
            $display("FAIL watchdog expired act %0d cycles exp < 150000", cyc);
            #1 report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        seq_cmp++;
        if (!ok) begin
            seq_bad++;
            $display("FAIL %s act %h exp %h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic model_iv();
        mh = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
               32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    endtask

    task automatic model_hash(input logic [15:0] p);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        for (int i = 0; i < 16; i++) w[i] = {<<8{mem[10'(p + 16'(i))]}};
        for (int i = 16; i < 64; i++)
            w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
                 + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
        v = mh;
        for (int r = 0; r < 64; r++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) | (~v[4] & v[6])) + K_TAB[r] + w[r];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) | (v[2] & (v[0] | v[1])));
            for (int j = 7; j > 0; j--) v[j] = v[j-1];
            v[4] = v[4] + t1;
            v[0] = t1 + t2;
        end
        for (int j = 0; j < 8; j++) mh[j] = mh[j] + v[j];
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_a = a; h_d = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!(mem[MBOX[9:0]] == 0 && exp_wa.size() == 0 && exp_ra.size() == 0) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 20000, tag, mem[MBOX[9:0]], 32'd0);
    endtask

    task automatic do_hash(input logic [15:0] p);
        for (int i = 0; i < 16; i++) exp_ra.push_back(p + 16'(i));
        model_hash(p);
        exp_wa.push_back(MBOX); exp_wd.push_back(0); exp_wt.push_back("R8");
        host_wr(MBOX, {15'd0, p[14:0], 2'd1});
        wait_done("R8 hash completion");
    endtask

    task automatic do_dump(input logic [15:0] p);
        for (int i = 0; i < 8; i++) begin
            exp_wa.push_back(p + 16'(i)); exp_wd.push_back(mh[i]); exp_wt.push_back("R5");
        end
        exp_wa.push_back(MBOX); exp_wd.push_back(0); exp_wt.push_back("R8");
        host_wr(MBOX, {15'd0, p[14:0], 2'd2});
        wait_done("R8 digest completion");
        for (int i = 0; i < 8; i++)
            chk(mem[10'(p + 16'(i))] == mh[i], "R5 digest word in memory", mem[10'(p + 16'(i))], mh[i]);
        model_iv();
    endtask

    initial begin
        logic [31:0] kat [8];
        logic [31:0] save [8];
        kat = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
        model_iv();
        repeat (4) begin
            @(negedge clk);
            chk(mem_req_valid == 1'b0, "R10 no request in reset", 32'(mem_req_valid), 32'd0);
        end
        h_we = 1'b1; h_a = MBOX; h_d = 0;
        @(negedge clk);
        h_we = 1'b0;
        rst = 1'b0;

        // R6: digest right after reset is the initial value
        do_dump(16'h0100);
        chk(mem[10'h100] == 32'h6a09e667, "R6 first digest word after reset", mem[10'h100], 32'h6a09e667);

        // R3/R4: known-answer block, little-endian storage
        host_wr(16'h0040, 32'h80636261);
        for (int i = 1; i < 15; i++) host_wr(16'h0040 + 16'(i), 32'd0);
        host_wr(16'h004f, 32'h18000000);
        do_hash(16'h0040);
        do_dump(16'h0100);
        for (int i = 0; i < 8; i++)
            chk(mem[10'h100 + 10'(i)] == kat[i], "R4 known-answer digest", mem[10'h100 + 10'(i)], kat[i]);

        // R1: idle mailbox, then a zero code under a nonzero word
        repeat (200) @(negedge clk);
        chk(exp_wa.size() == 0 && mem[MBOX[9:0]] == 0, "R1 idle leaves mailbox zero", mem[MBOX[9:0]], 32'd0);
        host_wr(MBOX, 32'h0000_0400);
        repeat (200) @(negedge clk);
        chk(mem[MBOX[9:0]] == 32'h0000_0400, "R1 code 0 word not cleared", mem[MBOX[9:0]], 32'h0000_0400);
        host_wr(MBOX, 32'd0);
        repeat (20) @(negedge clk);

        // R4 chaining with R7 no-op in between
        for (int i = 0; i < 32; i++) host_wr(16'h0200 + 16'(i), $urandom);
        do_hash(16'h0200);
        exp_wa.push_back(MBOX); exp_wd.push_back(0); exp_wt.push_back("R7");
        host_wr(MBOX, 32'h0000_0803);
        wait_done("R7 no-op completion");
        do_hash(16'h0210);
        save = mh;
        do_dump(16'h0120);
        for (int i = 0; i < 8; i++)
            chk(mem[10'h120 + 10'(i)] == save[i], "R7 R4 chained digest unchanged by no-op", mem[10'h120 + 10'(i)], save[i]);

        // R6: digest again returns the initial value
        do_dump(16'h0130);
        chk(mem[10'h130] == 32'h6a09e667 && mem[10'h137] == 32'h5be0cd19,
            "R6 state reset after digest", mem[10'h137], 32'h5be0cd19);

        // R2: pointer with high bits set, upper mailbox bits ignored
        for (int i = 0; i < 16; i++) host_wr(16'h23f0 + 16'(i), $urandom);
        for (int i = 0; i < 16; i++) exp_ra.push_back(16'h23f0 + 16'(i));
        model_hash(16'h23f0);
        exp_wa.push_back(MBOX); exp_wd.push_back(0); exp_wt.push_back("R8");
        host_wr(MBOX, 32'hABCE_0000 | {15'd0, 15'h23f0, 2'd1});
        wait_done("R2 high pointer hash");
        do_dump(16'h7300);
        chk(exp_ra.size() == 0, "R2 all reads at pointer", 32'(exp_ra.size()), 32'd0);

        repeat (20) @(negedge clk);
        report();
        $finish;
    end
endmodule